// File: doc/BRIEF.md
# PFC Status Good Flag Generator

This block drives one power-good status line for the converter that follows a power factor correction stage. The line is high only when the stage runs normally with its output held at the nominal level. It goes low when the stage is switched off, when a fault is present, when the output is over voltage, or while the stage is still starting up.

Startup is tracked by a latch. Every off phase and every fault sets it. It clears only once the error amplifier has stopped charging its output capacitor, which shows that regulation has been reached. The error amplifier's "charging" indication arrives asynchronously. It passes through a two-flop synchroniser and must then read "not charging" for a set number of clocks before the latch clears.

During an overvoltage event the block asks for the power switch to be held off. It also raises a blanking line that tells the on-time circuit not to count that interval as dead time.

Top module: `pfc_good_flag`

## Requirements
- R1: While reset is asserted and after it is released, the startup output is 1 and the good flag is 0.
- R2: If the run input is 0 at a clock edge, the startup output is 1 and the good flag is 0 after that edge.
- R3: If the fault input is 1 at a clock edge, the startup output is 1 and the good flag is 0 after that edge.
- R4: The startup latch clears only when the charging input (1 = charging) has been 0 at the synchroniser output for SETTLE consecutive clocks with run=1 and fault=0. After the input falls, this takes SETTLE+3 clock edges.
- R5: A drop of the charging input that is shorter than the settle window restarts the window and leaves the startup latch set.
- R6: The good flag is registered. After an edge it equals the values present before that edge of run AND NOT fault AND NOT overvoltage AND NOT startup.
- R7: The driver-inhibit output is 1 whenever the overvoltage input is 1, the run input is 0 or the fault input is 1, and it is 0 otherwise (combinational).
- R8: The on-time blanking output is 1 exactly when the overvoltage input is 1 while the run input is 1.
- R9: Overvoltage does not set the startup latch. The good flag comes back one edge after overvoltage clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 = active, 0 = off phase |
| fault_i | input | 1 | 1 = fault detected |
| ovp_i | input | 1 | 1 = output overvoltage |
| ea_charging_i | input | 1 | Asynchronous; 1 = error amplifier still charging |
| good_o | output | 1 | Registered power-good flag |
| startup_o | output | 1 | Startup latch state |
| drv_inhibit_o | output | 1 | Hold power switch off |
| ton_blank_o | output | 1 | Tell on-time logic to ignore the overvoltage interval |

## Verification
On every cycle, the assertions check that off and fault set the startup latch, and that the good flag never rises without a clean run state before it. They also check that blanking implies inhibit and that startup only rises because of an off phase or a fault. Only the bench scenarios can show three things: the exact settle delay through the synchroniser, that a short drop of the charging input restarts the window, and that the flag comes straight back after an overvoltage without waiting through a new startup.

// File: rtl/pfc_good_flag.sv
module pfc_good_flag #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic fault_i,
  input  logic ovp_i,
  input  logic ea_charging_i,
  output logic good_o,
  output logic startup_o,
  output logic drv_inhibit_o,
  output logic ton_blank_o
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          chg_s1, chg_s2;
  logic [CW-1:0] quiet_cnt;
  logic          stop_req;
  logic          settled;

  assign stop_req = !run_i || fault_i;
  assign settled  = (quiet_cnt == CW'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_s1 <= 1'b1;
      chg_s2 <= 1'b1;
    end else begin
      chg_s1 <= ea_charging_i;
      chg_s2 <= chg_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  quiet_cnt <= '0;
    else if (stop_req || chg_s2) quiet_cnt <= '0;
    else if (!settled)           quiet_cnt <= quiet_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        startup_o <= 1'b1;
    else if (stop_req) startup_o <= 1'b1;
    else if (settled)  startup_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_o <= 1'b0;
    else        good_o <= run_i && !fault_i && !ovp_i && !startup_o;
  end

  assign drv_inhibit_o = ovp_i || stop_req;
  assign ton_blank_o   = ovp_i && run_i;

  a_r2_off_sets_startup: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (startup_o && !good_o));

  a_r3_fault_sets_startup: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (startup_o && !good_o));

  a_r6_good_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_o) |-> $past(run_i && !fault_i && !ovp_i && !startup_o));

  a_r7_good_not_after_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    good_o |-> !$past(drv_inhibit_o));

  a_r8_blank_implies_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    ton_blank_o |-> drv_inhibit_o);

  a_r9_startup_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup_o) |-> $past(!run_i || fault_i));

  a_r4_clear_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(startup_o) |-> $past(run_i && !fault_i));
endmodule

// File: tb/pfc_good_flag_bench.sv
module pfc_good_flag_bench;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, fault_i = 1'b0, ovp_i = 1'b0, ea_charging_i = 1'b1;
  logic good_o, startup_o, drv_inhibit_o, ton_blank_o;

  int checks = 0, fails = 0;
  string tag = "R1";

  bit m_good = 0, m_start = 1;
  int m_quiet = 0;
  bit hist[$];

  always #10 clk = ~clk;

  pfc_good_flag #(.SETTLE(SETTLE)) u_pfc_good_flag (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .fault_i(fault_i), .ovp_i(ovp_i),
    .ea_charging_i(ea_charging_i), .good_o(good_o), .startup_o(startup_o),
    .drv_inhibit_o(drv_inhibit_o), .ton_blank_o(ton_blank_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_good = 0; m_start = 1; m_quiet = 0; hist.delete();
    end else begin
      bit old_start, seen;
      int old_quiet;
      old_start = m_start;
      old_quiet = m_quiet;
      seen = (hist.size() >= 2) ? hist[hist.size()-2] : 1'b1;
      m_good = run_i && !fault_i && !ovp_i && !old_start;
      if (!run_i || fault_i) m_start = 1;
      else if (old_quiet >= SETTLE) m_start = 0;
      if (!run_i || fault_i || seen) m_quiet = 0;
      else if (m_quiet < SETTLE) m_quiet++;
      hist.push_back(ea_charging_i);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(tag, "good_o", good_o, m_good);
    check(tag, "startup_o", startup_o, m_start);
    check("R7", "drv_inhibit_o", drv_inhibit_o, ovp_i || !run_i || fault_i);
    check("R8", "ton_blank_o", ton_blank_o, ovp_i && run_i);
  endtask

  task automatic step(int n, logic run, logic flt, logic ovp, logic chg);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      run_i = run; fault_i = flt; ovp_i = ovp; ea_charging_i = chg;
      #1 compare();
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", "good_o in reset", good_o, 1'b0);
    check("R1", "startup_o in reset", startup_o, 1'b1);
    rst_n = 1'b1;
    step(3, 0, 0, 0, 1);
    tag = "R2"; step(4, 0, 0, 0, 0);
    tag = "R5"; step(6, 1, 0, 0, 1);
    step(3, 1, 0, 0, 0);
    step(3, 1, 0, 0, 1);
    @(negedge clk); check("R5", "startup held after short drop", startup_o, 1'b1);
    tag = "R4"; step(SETTLE + 2, 1, 0, 0, 0);
    check("R4", "startup not yet clear", startup_o, 1'b1);
    step(1, 1, 0, 0, 0);
    @(negedge clk); check("R4", "startup cleared at SETTLE+3", startup_o, 1'b0);
    tag = "R6"; step(4, 1, 0, 0, 0);
    check("R6", "good in regulation", good_o, 1'b1);
    tag = "R9"; step(3, 1, 0, 1, 0);
    check("R9", "startup kept through ovp", startup_o, 1'b0);
    step(3, 1, 0, 0, 0);
    check("R9", "good back after ovp", good_o, 1'b1);
    tag = "R3"; step(2, 1, 1, 0, 0);
    check("R3", "good low on fault", good_o, 1'b0);
    step(3, 1, 0, 0, 0);
    check("R3", "good held until settle", good_o, 1'b0);
    tag = "R4"; step(SETTLE + 5, 1, 0, 0, 0);
    tag = "R2"; step(2, 0, 0, 1, 0);
    check("R2", "good low when off", good_o, 1'b0);
    tag = "R6"; step(SETTLE + 6, 1, 0, 0, 0);
    check("R6", "good after restart", good_o, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule